// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Controller

This block chooses, every clock cycle, at most one hardware thread context to launch an instruction into a shared pipeline. Each thread presents an "instruction available" flag, a 3-bit lookahead value and a memory-operation flag for the instruction it has waiting. The lookahead value tells the controller how many of the thread's following instructions do not depend on this one. Because of it, a thread can keep issuing while earlier instructions are still in the pipeline, as long as that independence budget lasts.

When a thread has used up its budget, it must wait. It waits until the pipeline latency since its latest issue has elapsed. If it has an outstanding memory operation, it also waits until a completion strobe reports that the memory result is back. The controller picks among eligible threads in round-robin order, starting just after the thread that issued last. The issued thread number is presented combinationally in the same cycle and is registered at the clock edge.

Top module: `lookahead_issue`

## Requirements
- R1: At most one thread is issued per cycle, and only a thread whose ready input is high is ever issued.
- R2: After reset no thread has an outstanding dependence, and the first search starts at thread 0.
- R3: Among eligible threads, the one chosen is the first found when scanning upward from the thread after the last issued one, wrapping at THREADS.
- R4: A thread that issues with no outstanding dependence and lookahead 0 is not issued again for LAT cycles. With its ready input held high and no other thread ready, its next issue comes exactly LAT cycles later.
- R5: A thread that issues with no outstanding dependence and lookahead L (bits [3t+2:3t] of look_i for thread t) may issue L more instructions on the following cycles before it must wait.
- R6: When a thread issues while a dependence is outstanding, its remaining budget becomes the smaller of (old budget − 1) and the new instruction's lookahead.
- R7: An instruction issued with its mem_i bit high keeps the thread's dependence outstanding until a done_i pulse for that thread arrives. The pulse takes effect from the next cycle.
- R8: A done_i pulse in the same cycle as a memory-operation issue of the same thread leaves the thread waiting for a further pulse.
- R9: A done_i pulse for a thread with no memory operation outstanding has no effect; in particular it does not shorten the LAT wait.
- R10: In a cycle with no eligible thread, issue_valid_o is low and the round-robin position is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | THREADS | Thread has an instruction waiting |
| look_i | input | 3*THREADS | Lookahead of each thread's waiting instruction, thread t in bits [3t+2:3t] |
| mem_i | input | THREADS | Waiting instruction is a memory operation |
| done_i | input | THREADS | Memory result returned for the thread |
| issue_valid_o | output | 1 | An instruction is issued this cycle |
| issue_tid_o | output | TID_W | Number of the issued thread |

## Verification
A memory-result strobe and a new memory-operation issue can land on the same thread in the same cycle. The clear from the strobe then competes with the set from the issue. A directed sequence provokes this by giving a thread a lookahead of 1 on a memory operation and then issuing a second memory operation in the cycle the strobe arrives. The check is that the thread then stays silent, past the pipeline latency, until a second strobe. Random stimulus, with strobes and memory flags on every thread, produces the same collision many more times, and each of those cycles is compared with a bench reference model.

// File: rtl/lookahead_issue.sv
module lookahead_issue #(
  parameter int THREADS = 8,
  parameter int LAT     = 21,
  parameter int LA_W    = 3,
  parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [THREADS-1:0]      ready_i,
  input  logic [LA_W*THREADS-1:0] look_i,
  input  logic [THREADS-1:0]      mem_i,
  input  logic [THREADS-1:0]      done_i,
  output logic                    issue_valid_o,
  output logic [TID_W-1:0]        issue_tid_o
);

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0]     timer_q  [THREADS];
  logic [LA_W-1:0]   credit_q [THREADS];
  logic [THREADS-1:0] memw_q;
  logic [THREADS-1:0] busy, elig;
  logic [TID_W-1:0]  last_q;

  always_comb begin
    issue_valid_o = 1'b0;
    issue_tid_o   = last_q;
    for (int i = 1; i <= THREADS; i++) begin
      if (!issue_valid_o && elig[(int'(last_q) + i) % THREADS]) begin
        issue_valid_o = 1'b1;
        issue_tid_o   = TID_W'((int'(last_q) + i) % THREADS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             last_q <= TID_W'(THREADS - 1);
    else if (issue_valid_o) last_q <= issue_tid_o;
  end

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic            hit;
      logic [LA_W-1:0] lk, cdec;

      assign busy[t] = (timer_q[t] != '0) || memw_q[t];
      assign elig[t] = ready_i[t] && (!busy[t] || credit_q[t] != '0);
      assign hit     = issue_valid_o && (issue_tid_o == TID_W'(t));
      assign lk      = look_i[t*LA_W +: LA_W];
      assign cdec    = credit_q[t] - 1'b1;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          timer_q[t]  <= '0;
          credit_q[t] <= '0;
          memw_q[t]   <= 1'b0;
        end else begin
          memw_q[t] <= (hit && mem_i[t]) || (memw_q[t] && !done_i[t]);
          if (hit) begin
            timer_q[t]  <= CW'(LAT - 1);
            credit_q[t] <= (busy[t] && cdec < lk) ? cdec : lk;
          end else if (timer_q[t] != '0) begin
            timer_q[t] <= timer_q[t] - 1'b1;
          end
        end
      end

      if (LAT > 1) begin : g_spacing
        a_r4_zero_lookahead_waits: assert property (@(posedge clk) disable iff (!rst_n)
          (hit && !busy[t] && lk == '0) |=> !hit);
      end

      a_r7_mem_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (memw_q[t] && credit_q[t] == '0) |-> !hit);

      a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mem_i[t] && done_i[t]) |=> busy[t]);
    end
  endgenerate

  a_r1_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> ready_i[issue_tid_o]);

  a_r10_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid_o |=> $stable(last_q));

endmodule

// File: tb/lookahead_issue_test.sv
module lookahead_issue_test;
  localparam int N   = 8;
  localparam int LAT = 21;
  localparam int TW  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]   ready_i = '0, mem_i = '0, done_i = '0;
  logic [3*N-1:0] look_i = '0;
  logic           issue_valid_o;
  logic [TW-1:0]  issue_tid_o;

  lookahead_issue #(.THREADS(N), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .look_i(look_i),
    .mem_i(mem_i), .done_i(done_i),
    .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_tm[N], m_cr[N];
  bit m_mw[N];
  int m_last;
  bit got_v;
  int got_t;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3*N-1:0] lk1(int t, int l);
    logic [3*N-1:0] v = '0;
    v[t*3 +: 3] = 3'(l);
    return v;
  endfunction

  task automatic step(logic [N-1:0] r, logic [3*N-1:0] l, logic [N-1:0] m,
                      logic [N-1:0] d, string tag);
    bit ev, busy;
    int et, idx, lk;
    @(negedge clk);
    ready_i = r; look_i = l; mem_i = m; done_i = d;
    #2;
    ev = 0; et = m_last;
    for (int i = 1; i <= N; i++) begin
      idx = (m_last + i) % N;
      busy = (m_tm[idx] != 0) || m_mw[idx];
      if (!ev && r[idx] && (!busy || m_cr[idx] > 0)) begin ev = 1; et = idx; end
    end
    got_v = issue_valid_o;
    got_t = int'(issue_tid_o);
    chk(got_v == ev && (!ev || got_t == et), tag,
        got_v ? got_t : -1, ev ? et : -1);
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      busy = (m_tm[t] != 0) || m_mw[t];
      lk = int'(l[t*3 +: 3]);
      if (ev && et == t) begin
        m_cr[t] = (busy && m_cr[t] - 1 < lk) ? m_cr[t] - 1 : lk;
        m_tm[t] = LAT - 1;
        m_mw[t] = m[t] || (m_mw[t] && !d[t]);
      end else begin
        if (m_tm[t] > 0) m_tm[t]--;
        m_mw[t] = m_mw[t] && !d[t];
      end
    end
    if (ev) m_last = et;
  endtask

  task automatic drain();
    repeat (LAT + 2) step('0, '0, '0, '1, "R10");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c1, c2, cnt_a, cnt_b;
    void'($urandom(32'h5eed1));
    for (int t = 0; t < N; t++) begin m_tm[t] = 0; m_cr[t] = 0; m_mw[t] = 0; end
    m_last = N - 1;
    repeat (3) @(posedge clk);
    #1;
    chk(issue_valid_o == 1'b0, "R10 reset idle", int'(issue_valid_o), 0);
    rst_n = 1'b1;

    step('1, '0, '0, '0, "R2");
    chk(got_v && got_t == 0, "R2 first pick", got_t, 0);
    for (int k = 1; k < 4; k++) begin
      step('1, '0, '0, '0, "R3");
      chk(got_v && got_t == k, "R3 round robin", got_t, k);
    end
    drain();

    c1 = -1; c2 = -1;
    for (int c = 0; c < 50; c++) begin
      step(N'(1) << 2, lk1(2, 0), '0, '0, "R4");
      if (got_v) begin if (c1 < 0) c1 = c; else if (c2 < 0) c2 = c; end
    end
    chk(c2 - c1 == LAT, "R4 spacing", c2 - c1, LAT);
    drain();

    cnt_a = 0; cnt_b = 0;
    for (int c = 0; c < 10; c++) begin
      step(N'(1) << 5, lk1(5, 3), '0, '0, "R5");
      if (got_v) begin if (c < 4) cnt_a++; else cnt_b++; end
    end
    chk(cnt_a == 4 && cnt_b == 0, "R5 burst length", cnt_a * 10 + cnt_b, 40);
    drain();

    step(N'(1) << 4, lk1(4, 7), '0, '0, "R6");
    step(N'(1) << 4, lk1(4, 1), '0, '0, "R6");
    step(N'(1) << 4, lk1(4, 7), '0, '0, "R6");
    chk(got_v == 1'b1, "R6 reduced budget used", int'(got_v), 1);
    step(N'(1) << 4, lk1(4, 7), '0, '0, "R6");
    chk(got_v == 1'b0, "R6 budget exhausted", int'(got_v), 0);
    drain();

    step(N'(1) << 1, lk1(1, 0), N'(1) << 1, '0, "R7");
    cnt_a = 0;
    for (int c = 0; c < 40; c++) begin
      step(N'(1) << 1, lk1(1, 0), '0, '0, "R7");
      if (got_v) cnt_a++;
    end
    chk(cnt_a == 0, "R7 held for memory", cnt_a, 0);
    step(N'(1) << 1, lk1(1, 0), '0, N'(1) << 1, "R7");
    chk(got_v == 1'b0, "R7 strobe cycle", int'(got_v), 0);
    step(N'(1) << 1, lk1(1, 0), '0, '0, "R7");
    chk(got_v && got_t == 1, "R7 released", got_t, 1);
    drain();

    step(N'(1) << 1, lk1(1, 1), N'(1) << 1, '0, "R8");
    step(N'(1) << 1, lk1(1, 0), N'(1) << 1, N'(1) << 1, "R8");
    chk(got_v && got_t == 1, "R8 collide issue", got_t, 1);
    cnt_a = 0;
    for (int c = 0; c < 30; c++) begin
      step(N'(1) << 1, lk1(1, 0), '0, '0, "R8");
      if (got_v) cnt_a++;
    end
    chk(cnt_a == 0, "R8 still waiting", cnt_a, 0);
    step(N'(1) << 1, lk1(1, 0), '0, N'(1) << 1, "R8");
    step(N'(1) << 1, lk1(1, 0), '0, '0, "R8");
    chk(got_v && got_t == 1, "R8 second strobe frees", got_t, 1);
    drain();

    c1 = -1; c2 = -1;
    for (int c = 0; c < 30; c++) begin
      step(N'(1) << 6, lk1(6, 0), '0, N'(1) << 6, "R9");
      if (got_v) begin if (c1 < 0) c1 = c; else if (c2 < 0) c2 = c; end
    end
    chk(c2 - c1 == LAT, "R9 strobe ignored", c2 - c1, LAT);
    drain();

    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r, m, d;
      logic [3*N-1:0] l;
      r = '0; m = '0; d = '0;
      for (int t = 0; t < N; t++) begin
        r[t] = ($urandom % 4) != 0;
        m[t] = ($urandom % 8) == 0;
        d[t] = ($urandom % 16) == 0;
      end
      l = 24'($urandom);
      step(r, l, m, d, "R1 R3 R5 R6 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule